// File: doc/BRIEF.md
# Core Boundary Scan Chain

This block is a serial test register that wraps the signals of a processor core. One cell stands on each core input, each miscellaneous core output and each bit of the core's data bus output. A test access port controller, which is outside this block, drives four one-cycle strobes into it: capture, shift, update and run-idle. It also supplies a mode bit that chooses internal test or external test. The chain responds only while the scan-select logic has chosen it. The host chooses it with a scan-select instruction whose opcode is 4'b0010, followed by a separate mode instruction.

Internal test exercises the core. Patterns shifted into the input cells drive the core inputs. A capture loads the core's outputs into the output cells. Each run-idle cycle gives the core exactly one clock pulse.

External test exercises the board wiring. A capture samples what the system drives onto the core inputs. The miscellaneous output pins follow their cells directly as bits move through the chain. The data bus pins change only on an update strobe, which loads them from a holding register. The core is never clocked in external test.

When the chain is not chosen, every pin passes its functional value straight through.

The strobes are decoded in a fixed priority into one operation per cycle. The named operations are OP_CAPTURE, OP_SHIFT, OP_UPDATE, OP_RUN and OP_HOLD. OP_HOLD applies when no strobe is active or the chain is not chosen.

Top module: `core_bscan_chain`

## Requirements
- R1: After reset all cells, the data-bus holding register and the core clock pulse are 0.
- R2: While chosen and shifting, `tdo` presents cell 0 and each clock moves every cell one place toward `tdo`, with `tdi` entering the top cell. The cell layout is fixed. Cells 0..N_IN-1 are the core inputs. The next N_MISC cells are the miscellaneous outputs. The top DATA_W cells are the data bus. A pattern shifted in LSB first therefore ends with bit k in cell k.
- R3: A capture in internal test (`ext_mode`=0) loads the miscellaneous and data output cells from the core outputs and leaves the input cells unchanged.
- R4: A capture in external test (`ext_mode`=1) loads the input cells from `sys_in_i` and leaves the output cells unchanged.
- R5: While chosen in internal test, `core_in_o` equals the input cells. Otherwise `core_in_o` equals `sys_in_i`.
- R6: While chosen in external test, `sys_misc_o` equals the miscellaneous cells in every cycle, including during shifting.
- R7: While chosen in external test, `sys_data_o` shows the holding register. That register changes only on an update, which loads it from the data cells.
- R8: Each run-idle cycle in internal test gives exactly one `core_clk_o` pulse, in the following cycle.
- R9: Run-idle in external test gives no `core_clk_o` pulse.
- R10: While not chosen, no strobe changes any cell.
- R11: While not chosen, `sys_misc_o` and `sys_data_o` equal the core outputs and `core_in_o` equals `sys_in_i`.
- R12: An update in internal test leaves the data-bus holding register unchanged.
- R13: Strobes have a fixed priority: capture first, then shift, then update, then run-idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chain_sel | input | 1 | Chain chosen by scan-select logic |
| ext_mode | input | 1 | 1 = external test, 0 = internal test |
| cap_dr | input | 1 | Capture strobe |
| shf_dr | input | 1 | Shift strobe |
| upd_dr | input | 1 | Update strobe |
| rti | input | 1 | Run-idle strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (cell 0) |
| sys_in_i | input | N_IN | System values on the core inputs |
| core_in_o | output | N_IN | Values applied to the core inputs |
| core_misc_i | input | N_MISC | Core miscellaneous outputs |
| core_data_i | input | DATA_W | Core data bus output |
| sys_misc_o | output | N_MISC | Miscellaneous pins toward the system |
| sys_data_o | output | DATA_W | Data bus pins toward the system |
| core_clk_o | output | 1 | One-cycle core clock pulse |

## Verification
The bench builds the block with N_IN=4, N_MISC=3 and DATA_W=8, which makes a 15-cell chain. Every segment boundary falls inside a short pattern, so one shift shows that inputs leave first and the data bus leaves last. The narrow segments also let distinct hex patterns show a capture that lands in the wrong segment, a holding register that moves early and a stray clock pulse.

// File: rtl/core_bscan_pkg.sv
package core_bscan_pkg;
    // One operation per cycle, decoded from the TAP strobes
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_CAPTURE,
        OP_SHIFT,
        OP_UPDATE,
        OP_RUN
    } bscan_op_e;
endpackage

// File: rtl/core_bscan_op_decode.sv
module core_bscan_op_decode
    import core_bscan_pkg::*;
(
    input  logic      chain_sel,
    input  logic      cap_dr,
    input  logic      shf_dr,
    input  logic      upd_dr,
    input  logic      rti,
    output bscan_op_e op
);
    always_comb begin
        op = OP_HOLD;
        if (chain_sel) begin
            if (cap_dr)      op = OP_CAPTURE;
            else if (shf_dr) op = OP_SHIFT;
            else if (upd_dr) op = OP_UPDATE;
            else if (rti)    op = OP_RUN;
        end
    end
endmodule

// File: rtl/core_bscan_cells.sv
module core_bscan_cells
    import core_bscan_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int N_MISC = 6,
    parameter int DATA_W = 32,
    localparam int N_OUT = N_MISC + DATA_W,
    localparam int LEN   = N_IN + N_OUT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bscan_op_e        op,
    input  logic             ext_mode,
    input  logic             tdi,
    input  logic [N_IN-1:0]  cap_in,
    input  logic [N_OUT-1:0] cap_out,
    output logic [LEN-1:0]   chain_q
);
    logic [LEN-1:0] chain_d;

    always_comb begin
        chain_d = chain_q;
        unique case (op)
            OP_CAPTURE: begin
                if (ext_mode) chain_d[N_IN-1:0]   = cap_in;
                else          chain_d[LEN-1:N_IN] = cap_out;
            end
            OP_SHIFT:   chain_d = {tdi, chain_q[LEN-1:1]};
            OP_HOLD, OP_UPDATE, OP_RUN: chain_d = chain_q;
            default:    chain_d = chain_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end
endmodule

// File: rtl/core_bscan_update.sv
module core_bscan_update
    import core_bscan_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bscan_op_e         op,
    input  logic              ext_mode,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         q <= '0;
        else if (op == OP_UPDATE && ext_mode) q <= d;
    end
endmodule

// File: rtl/core_bscan_clkgen.sv
module core_bscan_clkgen
    import core_bscan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bscan_op_e op,
    input  logic      ext_mode,
    output logic      pulse_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= (op == OP_RUN) && !ext_mode;
    end
endmodule

// File: rtl/core_bscan_chain.sv
module core_bscan_chain
    import core_bscan_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int N_MISC = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_sel,
    input  logic              ext_mode,
    input  logic              cap_dr,
    input  logic              shf_dr,
    input  logic              upd_dr,
    input  logic              rti,
    input  logic              tdi,
    output logic              tdo,
    input  logic [N_IN-1:0]   sys_in_i,
    output logic [N_IN-1:0]   core_in_o,
    input  logic [N_MISC-1:0] core_misc_i,
    input  logic [DATA_W-1:0] core_data_i,
    output logic [N_MISC-1:0] sys_misc_o,
    output logic [DATA_W-1:0] sys_data_o,
    output logic              core_clk_o
);
    localparam int N_OUT  = N_MISC + DATA_W;
    localparam int LEN    = N_IN + N_OUT;
    localparam int MISC_L = N_IN;
    localparam int DATA_L = N_IN + N_MISC;

    bscan_op_e         op;
    logic [LEN-1:0]    chain_q;
    logic [DATA_W-1:0] upd_q;

    core_bscan_op_decode u_dec (
        .chain_sel(chain_sel), .cap_dr(cap_dr), .shf_dr(shf_dr),
        .upd_dr(upd_dr), .rti(rti), .op(op)
    );

    core_bscan_cells #(.N_IN(N_IN), .N_MISC(N_MISC), .DATA_W(DATA_W)) u_cells (
        .clk(clk), .rst_n(rst_n), .op(op), .ext_mode(ext_mode), .tdi(tdi),
        .cap_in(sys_in_i), .cap_out({core_data_i, core_misc_i}),
        .chain_q(chain_q)
    );

    core_bscan_update #(.DATA_W(DATA_W)) u_upd (
        .clk(clk), .rst_n(rst_n), .op(op), .ext_mode(ext_mode),
        .d(chain_q[LEN-1:DATA_L]), .q(upd_q)
    );

    core_bscan_clkgen u_clk (
        .clk(clk), .rst_n(rst_n), .op(op), .ext_mode(ext_mode),
        .pulse_q(core_clk_o)
    );

    // Output process: pin steering by selection and mode
    always_comb begin
        tdo        = chain_q[0];
        core_in_o  = sys_in_i;
        sys_misc_o = core_misc_i;
        sys_data_o = core_data_i;
        if (chain_sel) begin
            if (ext_mode) begin
                sys_misc_o = chain_q[DATA_L-1:MISC_L];
                sys_data_o = upd_q;
            end else begin
                core_in_o  = chain_q[N_IN-1:0];
            end
        end
    end
endmodule

// File: rtl/core_bscan_chk.sv
module core_bscan_chk #(
    parameter int N_IN   = 8,
    parameter int N_MISC = 6,
    parameter int DATA_W = 32,
    localparam int LEN   = N_IN + N_MISC + DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chain_sel,
    input logic              ext_mode,
    input logic              cap_dr,
    input logic              shf_dr,
    input logic              upd_dr,
    input logic              rti,
    input logic              tdi,
    input logic [N_IN-1:0]   sys_in_i,
    input logic              core_clk_o,
    input logic [LEN-1:0]    chain_q,
    input logic [DATA_W-1:0] upd_q
);
    // R2
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_sel && shf_dr && !cap_dr) |=> chain_q[LEN-1] == $past(tdi));
    // R4
    ext_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_sel && ext_mode && cap_dr) |=> chain_q[N_IN-1:0] == $past(sys_in_i));
    // R7
    update_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chain_sel && ext_mode && upd_dr && !cap_dr && !shf_dr) |=> $stable(upd_q));
    // R8
    int_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_sel && !ext_mode && rti && !cap_dr && !shf_dr && !upd_dr) |=> core_clk_o);
    // R9
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_o |-> $past(chain_sel && rti && !ext_mode));
    // R10
    unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_sel |=> $stable(chain_q));
endmodule

bind core_bscan_chain core_bscan_chk #(.N_IN(N_IN), .N_MISC(N_MISC), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .chain_sel(chain_sel), .ext_mode(ext_mode),
    .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr), .rti(rti), .tdi(tdi),
    .sys_in_i(sys_in_i), .core_clk_o(core_clk_o), .chain_q(chain_q), .upd_q(upd_q)
);

// File: tb/tb_core_bscan_chain.sv
module tb_core_bscan_chain;
    localparam int NI = 4, NM = 3, DW = 8;
    localparam int L  = NI + NM + DW;

    logic clk = 0, rst_n = 0;
    logic chain_sel = 0, ext_mode = 0, cap_dr = 0, shf_dr = 0, upd_dr = 0, rti = 0, tdi = 0;
    logic tdo, core_clk_o;
    logic [NI-1:0] sys_in_i = '0, core_in_o;
    logic [NM-1:0] core_misc_i = '0, sys_misc_o;
    logic [DW-1:0] core_data_i = '0, sys_data_o;

    int checks = 0, errors = 0, pulses = 0;
    bit done = 0;
    logic [L-1:0] model = '0;

    always #2 clk = ~clk;
    always @(negedge clk) pulses += int'(core_clk_o);

    core_bscan_chain #(.N_IN(NI), .N_MISC(NM), .DATA_W(DW)) dut (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Shift a full pattern LSB first; returns what came out of tdo
    task automatic shift_vec(input logic [L-1:0] din, output logic [L-1:0] dout, input bit watch_misc);
        for (int i = 0; i < L; i++) begin
            @(negedge clk); tdi = din[i]; shf_dr = 1;
            #1 dout[i] = tdo;
            if (watch_misc && i > 0)
                chk("R6 misc follows cells", 64'(sys_misc_o), 64'(model[NI+NM-1:NI]));
            model = {din[i], model[L-1:1]};
        end
        @(negedge clk); shf_dr = 0;
        if (watch_misc) chk("R6 misc after shift", 64'(sys_misc_o), 64'(model[NI+NM-1:NI]));
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which) 0: cap_dr = 1; 1: upd_dr = 1; default: rti = 1; endcase
        @(negedge clk); cap_dr = 0; upd_dr = 0; rti = 0;
    endtask

    task automatic t_reset();
        logic [L-1:0] o;
        core_data_i = 8'h5A; core_misc_i = 3'b101; sys_in_i = 4'h9;
        #1;
        chk("R11 data pass", 64'(sys_data_o), 64'h5A);
        chk("R11 misc pass", 64'(sys_misc_o), 64'h5);
        chk("R11 inputs pass", 64'(core_in_o), 64'h9);
        chk("R1 pulse", 64'(core_clk_o), 0);
        chain_sel = 1; ext_mode = 1; #1;
        chk("R1 holding reg", 64'(sys_data_o), 0);
        chk("R1 misc cells", 64'(sys_misc_o), 0);
        shift_vec('0, o, 0);
        chk("R1 cells zero", 64'(o), 0);
    endtask

    task automatic t_shift();
        logic [L-1:0] o;
        chain_sel = 1; ext_mode = 0;
        shift_vec(15'h2B6D, o, 0);
        chk("R5 core inputs from cells", 64'(core_in_o), 64'hD);
        shift_vec(15'h1357, o, 0);
        chk("R2 shift out order", 64'(o), 64'h2B6D);
        chk("R2 tdo is cell 0", 64'(tdo), 64'(1'b1));
    endtask

    task automatic t_int_capture();
        logic [L-1:0] o;
        chain_sel = 1; ext_mode = 0;
        shift_vec(15'h4006, o, 0);
        core_data_i = 8'hC3; core_misc_i = 3'b110; sys_in_i = 4'hF;
        strobe(0);
        shift_vec('0, o, 0);
        chk("R3 intest capture", 64'(o), 64'({8'hC3, 3'b110, 4'h6}));
    endtask

    task automatic t_ext_capture_update();
        logic [L-1:0] o;
        chain_sel = 1; ext_mode = 1;
        model = '0;
        shift_vec({8'hA5, 3'b011, 4'h0}, o, 1);
        chk("R7 no change before update", 64'(sys_data_o), 0);
        chk("R5 extest inputs pass", 64'(core_in_o), 64'(sys_in_i));
        sys_in_i = 4'hB; core_data_i = 8'h11; core_misc_i = 3'b000;
        strobe(0);
        chk("R7 no change on capture", 64'(sys_data_o), 0);
        strobe(1);
        chk("R7 update loads data", 64'(sys_data_o), 64'hA5);
        shift_vec('0, o, 1);
        chk("R4 extest capture", 64'(o), 64'({8'hA5, 3'b011, 4'hB}));
        chk("R7 stable while shifting", 64'(sys_data_o), 64'hA5);
        // R12: update in internal test leaves holding register
        ext_mode = 0;
        shift_vec({8'h3C, 7'h0}, o, 0);
        strobe(1);
        ext_mode = 1; #1;
        chk("R12 intest update ignored", 64'(sys_data_o), 64'hA5);
    endtask

    task automatic t_run();
        chain_sel = 1; ext_mode = 0;
        @(negedge clk); pulses = 0; rti = 1;
        repeat (3) @(negedge clk);
        rti = 0;
        repeat (2) @(negedge clk);
        chk("R8 three pulses", 64'(pulses), 3);
        ext_mode = 1;
        @(negedge clk); pulses = 0; rti = 1;
        repeat (4) @(negedge clk);
        rti = 0;
        repeat (2) @(negedge clk);
        chk("R9 no pulse in extest", 64'(pulses), 0);
    endtask

    task automatic t_priority();
        logic [L-1:0] o;
        chain_sel = 1; ext_mode = 0;
        shift_vec('0, o, 0);
        core_data_i = 8'hE7; core_misc_i = 3'b001;
        @(negedge clk); pulses = 0; cap_dr = 1; shf_dr = 1; rti = 1; tdi = 1;
        @(negedge clk); cap_dr = 0; shf_dr = 0; rti = 0;
        repeat (2) @(negedge clk);
        chk("R13 capture beats run", 64'(pulses), 0);
        shift_vec('0, o, 0);
        chk("R13 capture beats shift", 64'(o), 64'({8'hE7, 3'b001, 4'h0}));
    endtask

    task automatic t_unselected();
        logic [L-1:0] o;
        chain_sel = 1; ext_mode = 0;
        shift_vec(15'h6A59, o, 0);
        chain_sel = 0; ext_mode = 1;
        core_data_i = 8'h42; core_misc_i = 3'b010; sys_in_i = 4'h7;
        @(negedge clk); pulses = 0;
        cap_dr = 1; @(negedge clk); cap_dr = 0;
        shf_dr = 1; tdi = 1; repeat (5) @(negedge clk); shf_dr = 0;
        upd_dr = 1; @(negedge clk); upd_dr = 0;
        ext_mode = 0; rti = 1; @(negedge clk); rti = 0; @(negedge clk);
        chk("R10 no pulse unselected", 64'(pulses), 0);
        chk("R11 data pass unselected", 64'(sys_data_o), 64'h42);
        chk("R11 inputs pass unselected", 64'(core_in_o), 64'h7);
        chain_sel = 1;
        shift_vec('0, o, 0);
        chk("R10 cells unchanged", 64'(o), 64'h6A59);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_shift();
        t_int_capture();
        t_ext_capture_update();
        t_run();
        t_priority();
        t_unselected();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule